// File: doc/BRIEF.md
# I2C Master SCL Waveform Generator

This block produces the serial clock line for an I2C master. It runs on the system clock and advances only on a single-cycle enable pulse, `presc_tick`, which comes from an external prescaler. Each SCL period has a low part and then a high part. Each part has its own programmable length: the stored 16-bit divide value plus a fixed offset `OFFSET`, counted in prescaler ticks.

Software sets the two divide values through a small register bus. Word address 0 holds the low-time value and word address 1 holds the high-time value. Both values sit in bits 15:0, and the upper half of each word is always zero. The registers accept writes only while `run_en` is 0, which is the module's reset-control bit. When `run_en` and `master_mode` are both 1, the block starts a new SCL period with the low part. At any other time SCL is released high and the phase counter is cleared.

The block keeps its own copy of both phase lengths, loaded while `run_en` is 0, so a running period always uses consistent lengths. The bus has a read latency of one clock.

Top module: `scl_wavegen`

## Requirements
- R1: After a synchronous reset, `scl_o` is 1 and both divide values read back as 0.
- R2: A write to word address 0 sets the low divide value from bits 15:0 of the write data. A write to word address 1 sets the high divide value. Read data appears on `bus_rdata` one clock after `bus_rd`.
- R3: Bits 31:16 of both divider words read as 0. Writes to those bits change nothing. Any other address reads 0 and ignores writes.
- R4: A write made while `run_en` is 1 leaves both divide values unchanged.
- R5: While active, SCL stays low for (low value + OFFSET) prescaler ticks in every period.
- R6: While active, SCL stays high for (high value + OFFSET) prescaler ticks in every period.
- R7: Each period starts with the low part. On the clock edge where the block becomes active, and that edge has no tick, `scl_o` goes to 0.
- R8: While `run_en` or `master_mode` is 0, `scl_o` is 1 and the phase counter is cleared, so the next active period restarts at the low part.
- R9: On a clock edge with no tick, an active SCL keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address (0 = low value, 1 = high value) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| run_en | input | 1 | Module reset-control bit (0 = held in reset, registers writable) |
| master_mode | input | 1 | 1 when the module operates as master |
| presc_tick | input | 1 | One-cycle prescaled clock enable |
| scl_o | output | 1 | Generated serial clock, registered |

## Verification
Two events can land on the same clock edge: a divider write and the switch of `run_en` to 1. The bench provokes this by dropping the write strobe and raising `run_en` at the same sampling point, so the write lands on the last unlocked edge. The first period that follows must then use the newly written length. The second such case is a phase boundary tick that coincides with `master_mode` falling, or with irregular ticks. There the reference model must see SCL released at once and the next period restart low. Both cases are judged by comparing `scl_o` with the model on every clock.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  localparam int NUM_DIV  = 2;
  localparam int IDX_LOW  = 0;
  localparam int IDX_HIGH = 1;
endpackage

// File: rtl/scl_divregs.sv
module scl_divregs #(
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              lock,
  input  logic                              wr,
  input  logic                              rd,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [DATA_W-1:0]                 rdata,
  output logic [scl_pkg::NUM_DIV-1:0][DIV_W-1:0] div_q,
  output logic [scl_pkg::NUM_DIV-1:0][DIV_W-1:0] div_nxt
);
  import scl_pkg::*;

  logic            wr_ok;
  logic [DIV_W-1:0] rd_sel;

  assign wr_ok = wr && !lock;

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    logic hit;
    assign hit = wr_ok && (addr == ADDR_W'(g));
    assign div_nxt[g] = hit ? wdata[DIV_W-1:0] : div_q[g];
    always_ff @(posedge clk) begin
      if (rst) div_q[g] <= '0;
      else     div_q[g] <= div_nxt[g];
    end
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_DIV; i++) begin
      if (addr == ADDR_W'(i)) rd_sel = div_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= {{(DATA_W-DIV_W){1'b0}}, rd_sel};
  end
endmodule

// File: rtl/scl_len_latch.sv
module scl_len_latch #(
  parameter int DIV_W  = 16,
  parameter int OFFSET = 5,
  parameter int LEN_W  = DIV_W + 1
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   hold,
  input  logic [scl_pkg::NUM_DIV-1:0][DIV_W-1:0] div_nxt,
  output logic [LEN_W-1:0]                       len_lo,
  output logic [LEN_W-1:0]                       len_hi
);
  import scl_pkg::*;

  localparam logic [LEN_W-1:0] OFS = LEN_W'(OFFSET);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_lo <= OFS;
      len_hi <= OFS;
    end else if (!hold) begin
      len_lo <= LEN_W'(div_nxt[IDX_LOW])  + OFS;
      len_hi <= LEN_W'(div_nxt[IDX_HIGH]) + OFS;
    end
  end
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             tick,
  input  logic [LEN_W-1:0] len_lo,
  input  logic [LEN_W-1:0] len_hi,
  output scl_pkg::phase_e  phase_nxt,
  output logic [LEN_W-1:0] cnt,
  output logic [LEN_W-1:0] cur_len
);
  import scl_pkg::*;

  phase_e           phase;
  logic [LEN_W-1:0] cnt_nxt;
  logic             last;

  assign cur_len = (phase == PH_HIGH) ? len_hi : len_lo;
  assign last    = (cnt == cur_len - LEN_W'(1));

  always_comb begin
    cnt_nxt   = cnt;
    phase_nxt = phase;
    if (!active) begin
      cnt_nxt   = '0;
      phase_nxt = PH_LOW;
    end else if (tick) begin
      if (last) begin
        cnt_nxt   = '0;
        phase_nxt = (phase == PH_LOW) ? PH_HIGH : PH_LOW;
      end else begin
        cnt_nxt = cnt + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= PH_LOW;
    end else begin
      cnt   <= cnt_nxt;
      phase <= phase_nxt;
    end
  end
endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen #(
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int OFFSET = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              run_en,
  input  logic              master_mode,
  input  logic              presc_tick,
  output logic              scl_o
);
  import scl_pkg::*;

  localparam int LEN_W = DIV_W + 1;

  logic [NUM_DIV-1:0][DIV_W-1:0] div_q;
  logic [NUM_DIV-1:0][DIV_W-1:0] div_nxt;
  logic [DIV_W-1:0]              div_lo;
  logic [DIV_W-1:0]              div_hi;
  logic [LEN_W-1:0]              len_lo;
  logic [LEN_W-1:0]              len_hi;
  logic [LEN_W-1:0]              cnt;
  logic [LEN_W-1:0]              cur_len;
  logic                          active;
  phase_e                        phase_nxt;

  assign active = run_en && master_mode;
  assign div_lo = div_q[IDX_LOW];
  assign div_hi = div_q[IDX_HIGH];

  scl_divregs #(.DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst(rst), .lock(run_en), .wr(bus_wr), .rd(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .div_q(div_q), .div_nxt(div_nxt)
  );

  scl_len_latch #(.DIV_W(DIV_W), .OFFSET(OFFSET), .LEN_W(LEN_W)) i_len (
    .clk(clk), .rst(rst), .hold(run_en), .div_nxt(div_nxt),
    .len_lo(len_lo), .len_hi(len_hi)
  );

  scl_phase_ctr #(.LEN_W(LEN_W)) i_ctr (
    .clk(clk), .rst(rst), .active(active), .tick(presc_tick),
    .len_lo(len_lo), .len_hi(len_hi), .phase_nxt(phase_nxt),
    .cnt(cnt), .cur_len(cur_len)
  );

  always_ff @(posedge clk) begin
    if (rst)          scl_o <= 1'b1;
    else if (!active) scl_o <= 1'b1;
    else              scl_o <= (phase_nxt == PH_HIGH);
  end
endmodule

// File: rtl/scl_wavegen_chk.sv
module scl_wavegen_chk #(
  parameter int DIV_W = 16,
  parameter int LEN_W = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             run_en,
  input logic             master_mode,
  input logic             presc_tick,
  input logic             bus_wr,
  input logic             scl_o,
  input logic [DIV_W-1:0] div_lo,
  input logic [DIV_W-1:0] div_hi,
  input logic [LEN_W-1:0] cnt,
  input logic [LEN_W-1:0] cur_len
);
  logic seen;
  logic act;

  assign act = run_en && master_mode;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !act |=> scl_o); // R8

  AST_FIRST_PHASE_LOW: assert property (@(posedge clk) disable iff (rst)
    (seen && act && !$past(act) && !presc_tick) |=> !scl_o); // R7

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
    (seen && act && $past(act) && !presc_tick) |=> $stable(scl_o)); // R9

  AST_LOCKED_WHEN_RUNNING: assert property (@(posedge clk) disable iff (rst)
    (run_en && bus_wr) |=> ($stable(div_lo) && $stable(div_hi))); // R4

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt < cur_len); // R5
endmodule

bind scl_wavegen scl_wavegen_chk #(.DIV_W(DIV_W), .LEN_W(LEN_W)) i_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .master_mode(master_mode),
  .presc_tick(presc_tick), .bus_wr(bus_wr), .scl_o(scl_o),
  .div_lo(div_lo), .div_hi(div_hi), .cnt(cnt), .cur_len(cur_len)
);

// File: tb/test_scl_wavegen.sv
`timescale 1ns/1ps
module test_scl_wavegen;
  localparam int DIV_W  = 16;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;
  localparam int OFF    = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              run_en = 1'b0;
  logic              master_mode = 1'b0;
  logic              presc_tick = 1'b0;
  logic              scl_o;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    started = 1'b0;

  int   lo_m, hi_m, lo_s, hi_s, pos;
  logic exp_scl = 1'b1;

  always #4 clk = ~clk;

  scl_wavegen #(.DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(OFF)) i_scl_wavegen (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .run_en(run_en),
    .master_mode(master_mode), .presc_tick(presc_tick), .scl_o(scl_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: tick count since activation, compared with lengths latched while unlocked
  always @(posedge clk) begin
    if (rst) begin
      lo_m = 0; hi_m = 0; lo_s = 0; hi_s = 0; pos = 0; exp_scl = 1'b1;
    end else begin
      if (run_en && master_mode) begin
        if (presc_tick) pos++;
        exp_scl = ((pos % (lo_s + hi_s + 2*OFF)) < (lo_s + OFF)) ? 1'b0 : 1'b1;
      end else begin
        pos = 0;
        exp_scl = 1'b1;
      end
      if (!run_en) begin
        if (bus_wr && bus_addr == 0) lo_m = int'(bus_wdata[15:0]);
        if (bus_wr && bus_addr == 1) hi_m = int'(bus_wdata[15:0]);
        lo_s = lo_m;
        hi_s = hi_m;
      end
    end
  end

  always @(negedge clk) begin
    if (started) chk(scl_o === exp_scl, cur_req, 32'(scl_o), 32'(exp_scl));
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(bus_rdata === e, req, bus_rdata, e);
  endtask

  task automatic measure(input int exp_lo, input int exp_hi);
    int n;
    @(negedge clk);
    while (scl_o !== 1'b1) @(negedge clk);
    while (scl_o !== 1'b0) @(negedge clk);
    n = 0;
    while (scl_o === 1'b0) begin n++; @(negedge clk); end
    chk(n == exp_lo, "R5 low length", 32'(n), 32'(exp_lo));
    n = 0;
    while (scl_o === 1'b1) begin n++; @(negedge clk); end
    chk(n == exp_hi, "R6 high length", 32'(n), 32'(exp_hi));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    started = 1'b1;
    // R1 reset state
    cur_req = "R1";
    chk(scl_o === 1'b1, "R1 scl after reset", 32'(scl_o), 32'h1);
    rd_chk(0, 32'h0, "R1 low value");
    rd_chk(1, 32'h0, "R1 high value");
    // R2 / R3 register access
    cur_req = "R2";
    wr(0, 32'hABCD_0003);
    wr(1, 32'h1234_0002);
    rd_chk(0, 32'h0000_0003, "R2 low value");
    rd_chk(1, 32'h0000_0002, "R2 high value");
    cur_req = "R3";
    rd_chk(2, 32'h0, "R3 unmapped read");
    wr(2, 32'hFFFF_FFFF);
    rd_chk(0, 32'h0000_0003, "R3 unmapped write low");
    rd_chk(1, 32'h0000_0002, "R3 unmapped write high");
    // R7 / R5 / R6 running with a tick every clock
    cur_req = "R5 R6";
    @(negedge clk);
    master_mode = 1'b1; presc_tick = 1'b1; run_en = 1'b1;
    @(negedge clk);
    chk(scl_o === 1'b0, "R7 first phase low", 32'(scl_o), 32'h0);
    measure(3 + OFF, 2 + OFF);
    repeat (20) @(negedge clk);
    // R4 locked while running
    cur_req = "R4";
    wr(0, 32'h0000_0009);
    wr(1, 32'h0000_0007);
    rd_chk(0, 32'h0000_0003, "R4 low locked");
    rd_chk(1, 32'h0000_0002, "R4 high locked");
    measure(3 + OFF, 2 + OFF);
    // R8 master drop, R7 restart
    cur_req = "R8";
    master_mode = 1'b0;
    repeat (10) @(negedge clk);
    chk(scl_o === 1'b1, "R8 released high", 32'(scl_o), 32'h1);
    cur_req = "R7";
    master_mode = 1'b1;
    @(negedge clk);
    chk(scl_o === 1'b0, "R7 restart low", 32'(scl_o), 32'h0);
    repeat (30) @(negedge clk);
    // R9 irregular ticks
    cur_req = "R9";
    for (int i = 0; i < 300; i++) begin
      presc_tick = (($urandom % 3) == 0);
      if (i == 150) master_mode = 1'b0;
      if (i == 153) master_mode = 1'b1;
      @(negedge clk);
    end
    // R8 reset-control drop, minimum lengths, write on the last unlocked edge
    cur_req = "R8";
    presc_tick = 1'b1;
    run_en = 1'b0;
    @(negedge clk);
    chk(scl_o === 1'b1, "R8 reset-control released", 32'(scl_o), 32'h1);
    wr(0, 32'h0000_0000);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 1; bus_wdata = 32'h0000_0001;
    @(negedge clk);
    bus_wr = 1'b0; run_en = 1'b1;
    cur_req = "R5 R6";
    measure(OFF, 1 + OFF);
    repeat (40) @(negedge clk);
    started = 1'b0;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule